// File: doc/BRIEF.md
# Halt and Wake-up Controller

This block sequences a processor core into and out of a low-power halt state. A one-cycle halt strobe from the core stops the system clock and records the power-down status. While halted, the block watches four kinds of wake source: an external reset request, a watchdog overflow, interrupt requests, and falling edges on an 8-bit port whose pins are each enabled for wake-up by a mask bit. When one of them fires, the block leaves halt and reports in a two-bit action code how the core must restart.

The action depends on the source. A port edge resumes at the next instruction. An interrupt vectors into its handler if it is enabled and the stack has room, and otherwise resumes inline. A watchdog overflow asks for a warm reset and marks the time-out flag. An external reset asks for full initialization and clears both status flags. An interrupt that was already pending when halt was entered cannot wake the core until its request has dropped. The core, its memories and the watchdog counter are outside the block; only the control outputs are produced here.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After a cycle with rst_n low, halted=0, sysclk_en=1, pdf=0, tof=0 and wake_valid=0.
- R2: A halt_req while running (and no ext_rst) gives, one cycle later, halted=1, sysclk_en=0, pdf=1 and tof=0.
- R3: While halted, a 1-to-0 change between consecutive cycles on a port_in pin whose wake_mask bit is 1 wakes the block with action 0 (resume). Falling edges on pins whose mask bit is 0, and rising edges, do not wake it.
- R4: While halted, an interrupt request wakes the block. The action is 1 (take interrupt) when a waking request has its irq_en bit set and stack_full is 0. Otherwise it is 0 (resume).
- R5: An irq_req bit that is high in the cycle halt_req is accepted cannot wake the block. Once that bit has been low for a cycle during halt, it can wake the block again.
- R6: A wdt_ovf while halted wakes the block with action 2 (warm reset), sets tof and leaves pdf at 1.
- R7: An ext_rst in any state produces action 3 (full reset) one cycle later, with halted=0, pdf=0 and tof=0.
- R8: When several wake sources are present in the same cycle, the priority order is ext_rst, then wdt_ovf, then interrupt, then port edge.
- R9: A wdt_clr while running clears pdf and leaves tof unchanged. If halt_req is present in the same cycle, pdf is set.
- R10: A wdt_ovf while running leaves every output unchanged. A halt_req while halted leaves every output unchanged.
- R11: A wake gives a one-cycle wake_valid pulse, with halted low, in the cycle after the source is seen. wake_act keeps its code after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| halt_req | input | 1 | One-cycle halt strobe from the core |
| ext_rst | input | 1 | External reset request, already synchronized |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| wdt_clr | input | 1 | Watchdog clear instruction strobe |
| irq_req | input | IRQ_N | Interrupt request flags |
| irq_en | input | IRQ_N | Per-interrupt enable |
| stack_full | input | 1 | Return stack has no free entry |
| port_in | input | PORT_W | Synchronized port pins |
| wake_mask | input | PORT_W | Per-pin falling-edge wake enable |
| halted | output | 1 | Halt state |
| sysclk_en | output | 1 | System clock enable (low while halted) |
| pdf | output | 1 | Power-down status flag |
| tof | output | 1 | Watchdog time-out status flag |
| wake_valid | output | 1 | One-cycle pulse when a wake action is issued |
| wake_act | output | 2 | 0 resume, 1 take interrupt, 2 warm reset, 3 full reset |

## Verification
Every output is a register, so each result is due exactly one clock after the input cycle that causes it. A port edge counts when a pin differs from its value one cycle earlier, so it also appears one clock after the falling cycle. The bench drives inputs just after the falling clock edge. A behavioural model updates at the rising edge from those same inputs, and the model and the design are compared at the next falling edge. Directed checks sample at that same falling edge, one clock after their stimulus, and hold-off cases such as blocked interrupts and masked pins are sampled over several following cycles to show that no wake occurred.

// File: rtl/hwc_pkg.sv
// Package: shared types for the halt and wake-up controller.
// Assumes: two-bit action codes, decoded by the core in this order.
package hwc_pkg;
    typedef enum logic [1:0] {
        WAKE_RESUME = 2'd0,
        WAKE_VECTOR = 2'd1,
        WAKE_WARM   = 2'd2,
        WAKE_FULL   = 2'd3
    } wake_act_e;

    localparam int SRC_N = 4;
endpackage

// File: rtl/hwc_port_edge.sv
// Module: hwc_port_edge
// Finds falling edges on wake-enabled port pins by comparing each pin
// with its value one cycle earlier.
// Assumes: port_in is already synchronized to clk.
module hwc_port_edge #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] wake_mask,
    output logic              fall_any
);
    logic [PORT_W-1:0] prev_q;
    logic [PORT_W-1:0] fall_bits;

    // Hold the previous pin sample; reset loads the current pins so no edge is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= port_in;
        else        prev_q <= port_in;
    end

    // Per-pin falling-edge detect gated by the wake mask.
    genvar gi;
    generate
        for (gi = 0; gi < PORT_W; gi++) begin : g_pin
            assign fall_bits[gi] = prev_q[gi] & ~port_in[gi] & wake_mask[gi];
        end
    endgenerate

    // Reduce to a single wake request.
    always_comb fall_any = |fall_bits;
endmodule

// File: rtl/hwc_irq_gate.sv
// Module: hwc_irq_gate
// Decides which interrupt requests may wake the core and whether the
// wake should vector. Requests pending at halt entry are blocked until
// they drop.
// Assumes: halt_entry is only high while not halted.
module hwc_irq_gate #(
    parameter int IRQ_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halted,
    input  logic             halt_entry,
    input  logic [IRQ_N-1:0] irq_req,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic             stack_full,
    output logic             irq_wake,
    output logic             irq_vector
);
    logic [IRQ_N-1:0] blocked_q;
    logic [IRQ_N-1:0] live_bits;

    genvar gi;
    generate
        for (gi = 0; gi < IRQ_N; gi++) begin : g_irq
            // Latch a pending request at entry; release it once it drops during halt.
            always_ff @(posedge clk) begin
                if (!rst_n)          blocked_q[gi] <= 1'b0;
                else if (halt_entry) blocked_q[gi] <= irq_req[gi];
                else if (halted)     blocked_q[gi] <= blocked_q[gi] & irq_req[gi];
                else                 blocked_q[gi] <= 1'b0;
            end
            assign live_bits[gi] = irq_req[gi] & ~blocked_q[gi];
        end
    endgenerate

    // Wake if any unblocked request; vector only if one is enabled and stack has room.
    always_comb begin
        irq_wake   = |live_bits;
        irq_vector = (|(live_bits & irq_en)) & ~stack_full;
    end

    // R5
    property blocked_only_in_halt_p;
        @(posedge clk) disable iff (!rst_n) (!halted && !halt_entry) |=> (blocked_q == '0);
    endproperty
    blocked_only_in_halt_chk: assert property (blocked_only_in_halt_p);
endmodule

// File: rtl/hwc_wake_arb.sv
// Module: hwc_wake_arb
// Fixed-priority selection among wake sources and the action code.
// Assumes: external reset acts in any state; other sources only while halted.
module hwc_wake_arb
    import hwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halted,
    input  logic             ext_rst,
    input  logic             wdt_ovf,
    input  logic             irq_wake,
    input  logic             irq_vector,
    input  logic             port_wake,
    output logic             wake_hit,
    output wake_act_e        wake_code,
    output logic [SRC_N-1:0] grant
);
    // One-hot grant in priority order: external reset, watchdog, interrupt, port.
    always_comb begin
        grant    = '0;
        grant[0] = ext_rst;
        grant[1] = halted & wdt_ovf & ~ext_rst;
        grant[2] = halted & irq_wake & ~wdt_ovf & ~ext_rst;
        grant[3] = halted & port_wake & ~irq_wake & ~wdt_ovf & ~ext_rst;
        wake_hit = |grant;
    end

    // Map the granted source to its restart action.
    always_comb begin
        if (grant[0])      wake_code = WAKE_FULL;
        else if (grant[1]) wake_code = WAKE_WARM;
        else if (grant[2]) wake_code = irq_vector ? WAKE_VECTOR : WAKE_RESUME;
        else               wake_code = WAKE_RESUME;
    end

    // R8
    property single_grant_p;
        @(posedge clk) disable iff (!rst_n) $onehot0(grant);
    endproperty
    single_grant_chk: assert property (single_grant_p);
endmodule

// File: rtl/halt_wake_ctrl.sv
// Module: halt_wake_ctrl (top)
// Sequences halt entry and exit, keeps the power-down and time-out
// flags, and issues a registered wake action with a one-cycle pulse.
// Assumes: all inputs synchronous to clk; strobes are one cycle wide.
module halt_wake_ctrl
    import hwc_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int IRQ_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              ext_rst,
    input  logic              wdt_ovf,
    input  logic              wdt_clr,
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_en,
    input  logic              stack_full,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] wake_mask,
    output logic              halted,
    output logic              sysclk_en,
    output logic              pdf,
    output logic              tof,
    output logic              wake_valid,
    output logic [1:0]        wake_act
);
    logic             halted_q, pdf_q, tof_q, valid_q;
    wake_act_e        act_q;
    logic             halt_entry;
    logic             port_wake, irq_wake, irq_vector, wake_hit;
    wake_act_e        wake_code;
    logic [SRC_N-1:0] grant;

    // Halt is accepted only while running and not overridden by external reset.
    always_comb halt_entry = ~halted_q & halt_req & ~ext_rst;

    hwc_port_edge #(.PORT_W(PORT_W)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_in   (port_in),
        .wake_mask (wake_mask),
        .fall_any  (port_wake)
    );

    hwc_irq_gate #(.IRQ_N(IRQ_N)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted     (halted_q),
        .halt_entry (halt_entry),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .stack_full (stack_full),
        .irq_wake   (irq_wake),
        .irq_vector (irq_vector)
    );

    hwc_wake_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted     (halted_q),
        .ext_rst    (ext_rst),
        .wdt_ovf    (wdt_ovf),
        .irq_wake   (irq_wake),
        .irq_vector (irq_vector),
        .port_wake  (port_wake),
        .wake_hit   (wake_hit),
        .wake_code  (wake_code),
        .grant      (grant)
    );

    // State and flag sequencing: wake first, then halt entry, then watchdog clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
            pdf_q    <= 1'b0;
            tof_q    <= 1'b0;
            valid_q  <= 1'b0;
            act_q    <= WAKE_RESUME;
        end else begin
            valid_q <= 1'b0;
            if (wake_hit) begin
                halted_q <= 1'b0;
                valid_q  <= 1'b1;
                act_q    <= wake_code;
                if (wake_code == WAKE_FULL) begin
                    pdf_q <= 1'b0;
                    tof_q <= 1'b0;
                end else if (wake_code == WAKE_WARM) begin
                    tof_q <= 1'b1;
                end
            end else if (halt_entry) begin
                halted_q <= 1'b1;
                pdf_q    <= 1'b1;
                tof_q    <= 1'b0;
            end else if (!halted_q && wdt_clr) begin
                pdf_q <= 1'b0;
            end
        end
    end

    // Drive outputs from registered state.
    always_comb begin
        halted     = halted_q;
        sysclk_en  = ~halted_q;
        pdf        = pdf_q;
        tof        = tof_q;
        wake_valid = valid_q;
        wake_act   = act_q;
    end

    // R2
    property entry_flags_p;
        @(posedge clk) disable iff (!rst_n) $rose(halted_q) |-> (pdf_q && !tof_q);
    endproperty
    entry_flags_chk: assert property (entry_flags_p);

    // R6
    property warm_sets_tof_p;
        @(posedge clk) disable iff (!rst_n) (valid_q && act_q == WAKE_WARM) |-> tof_q;
    endproperty
    warm_sets_tof_chk: assert property (warm_sets_tof_p);

    // R7
    property full_clears_p;
        @(posedge clk) disable iff (!rst_n)
            (valid_q && act_q == WAKE_FULL) |-> (!pdf_q && !tof_q && !halted_q);
    endproperty
    full_clears_chk: assert property (full_clears_p);

    // R11
    property pulse_out_of_halt_p;
        @(posedge clk) disable iff (!rst_n) valid_q |-> !halted_q;
    endproperty
    pulse_out_of_halt_chk: assert property (pulse_out_of_halt_p);

    // R10
    property halted_holds_p;
        @(posedge clk) disable iff (!rst_n) (halted_q && !wake_hit) |=> (halted_q && $stable(pdf_q));
    endproperty
    halted_holds_chk: assert property (halted_holds_p);
endmodule

// File: tb/halt_wake_ctrl_bench.sv
`timescale 1ns/1ps
module halt_wake_ctrl_bench;
    localparam int PW = 8;
    localparam int IN = 4;

    logic clk = 1'b0;
    logic rst_n, halt_req, ext_rst, wdt_ovf, wdt_clr, stack_full;
    logic [IN-1:0] irq_req, irq_en;
    logic [PW-1:0] port_in, wake_mask;
    logic halted, sysclk_en, pdf, tof, wake_valid;
    logic [1:0] wake_act;

    int checks = 0;
    int failures = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // reference model state
    bit m_halt, m_pdf, m_tof, m_valid;
    int m_act;
    bit [PW-1:0] m_prev;
    bit [IN-1:0] m_blk;

    always #2.5 clk = ~clk;

    halt_wake_ctrl #(.PORT_W(PW), .IRQ_N(IN)) u_halt_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .ext_rst(ext_rst),
        .wdt_ovf(wdt_ovf), .wdt_clr(wdt_clr), .irq_req(irq_req), .irq_en(irq_en),
        .stack_full(stack_full), .port_in(port_in), .wake_mask(wake_mask),
        .halted(halted), .sysclk_en(sysclk_en), .pdf(pdf), .tof(tof),
        .wake_valid(wake_valid), .wake_act(wake_act)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural model: one update per rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        bit [PW-1:0] falls;
        bit [IN-1:0] live;
        bit [IN-1:0] nblk;
        falls = m_prev & ~port_in & wake_mask;
        live  = irq_req & ~m_blk;
        nblk  = 0;
        if (!rst_n) begin
            m_halt = 0; m_pdf = 0; m_tof = 0; m_valid = 0; m_act = 0;
        end else begin
            if (m_halt) nblk = m_blk & irq_req;
            else if (halt_req && !ext_rst) nblk = irq_req;
            m_valid = 0;
            if (ext_rst) begin
                m_halt = 0; m_valid = 1; m_act = 3; m_pdf = 0; m_tof = 0;
            end else if (m_halt) begin
                if (wdt_ovf) begin
                    m_halt = 0; m_valid = 1; m_act = 2; m_tof = 1;
                end else if (live != 0) begin
                    m_halt = 0; m_valid = 1;
                    m_act = ((live & irq_en) != 0 && !stack_full) ? 1 : 0;
                end else if (falls != 0) begin
                    m_halt = 0; m_valid = 1; m_act = 0;
                end
            end else if (halt_req) begin
                m_halt = 1; m_pdf = 1; m_tof = 0;
            end else if (wdt_clr) begin
                m_pdf = 0;
            end
            m_blk = nblk;
        end
        if (!rst_n) m_blk = 0;
        m_prev = port_in;
        started = 1'b1;
    end

    // Compare model and design on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 model halted", halted, m_halt);
            chk("R2 model sysclk_en", sysclk_en, !m_halt);
            chk("R9 model pdf", pdf, m_pdf);
            chk("R6 model tof", tof, m_tof);
            chk("R11 model wake_valid", wake_valid, m_valid);
            chk("R4 model wake_act", wake_act, m_act);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_halt();
        halt_req = 1; tick(); halt_req = 0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        rst_n = 0; halt_req = 0; ext_rst = 0; wdt_ovf = 0; wdt_clr = 0;
        stack_full = 0; irq_req = 0; irq_en = 0; port_in = 8'hFF; wake_mask = 8'h01;
        @(negedge clk);
        tick(3);
        chk("R1 halted", halted, 0);
        chk("R1 sysclk_en", sysclk_en, 1);
        chk("R1 pdf", pdf, 0);
        chk("R1 tof", tof, 0);
        chk("R1 wake_valid", wake_valid, 0);
        rst_n = 1; tick();

        // R2 halt entry
        pulse_halt();
        chk("R2 halted", halted, 1);
        chk("R2 sysclk_en", sysclk_en, 0);
        chk("R2 pdf", pdf, 1);
        chk("R2 tof", tof, 0);

        // R3 unmasked fall ignored, masked fall wakes
        port_in = 8'hFD; tick(3);
        chk("R3 unmasked fall ignored", halted, 1);
        port_in = 8'hFC; tick();
        chk("R3 masked fall wake", halted, 0);
        chk("R11 pulse", wake_valid, 1);
        chk("R3 resume code", wake_act, 0);
        tick();
        chk("R11 pulse ends", wake_valid, 0);
        chk("R11 code held", wake_act, 0);
        port_in = 8'hFE; tick();
        // R3 rising edge ignored while halted
        pulse_halt();
        port_in = 8'hFF; tick(2);
        chk("R3 rising ignored", halted, 1);
        ext_rst = 1; tick(); ext_rst = 0; tick();

        // R5 pending interrupt blocked, then R4 vector
        irq_en = 4'b0001; irq_req = 4'b0001;
        pulse_halt();
        tick(3);
        chk("R5 pending irq blocked", halted, 1);
        irq_req = 0; tick();
        chk("R5 still halted after drop", halted, 1);
        irq_req = 4'b0001; tick();
        chk("R4 vector wake", wake_act, 1);
        chk("R4 vector pulse", wake_valid, 1);
        irq_req = 0; tick();

        // R4 disabled interrupt resumes
        pulse_halt();
        irq_req = 4'b0010; tick();
        chk("R4 disabled resumes", wake_act, 0);
        chk("R4 disabled woke", halted, 0);
        irq_req = 0; tick();

        // R4 stack full resumes
        irq_en = 4'b0100; stack_full = 1;
        pulse_halt();
        irq_req = 4'b0100; tick();
        chk("R4 stack full resumes", wake_act, 0);
        chk("R4 stack full pulse", wake_valid, 1);
        irq_req = 0; stack_full = 0; tick();

        // R6 watchdog warm reset, R9 clear
        pulse_halt();
        wdt_ovf = 1; tick(); wdt_ovf = 0;
        chk("R6 warm code", wake_act, 2);
        chk("R6 tof set", tof, 1);
        chk("R6 pdf kept", pdf, 1);
        wdt_clr = 1; tick(); wdt_clr = 0;
        chk("R9 pdf cleared", pdf, 0);
        chk("R9 tof kept", tof, 1);

        // R10 running overflow ignored, halt_req while halted ignored
        wdt_ovf = 1; tick(); wdt_ovf = 0;
        chk("R10 running ovf no wake", wake_valid, 0);
        chk("R10 running ovf tof", tof, 1);
        chk("R10 running ovf halted", halted, 0);
        pulse_halt();
        pulse_halt();
        chk("R10 halt while halted", halted, 1);
        chk("R10 halt while halted valid", wake_valid, 0);

        // R8 watchdog beats interrupt and port edge
        irq_en = 4'b1000; irq_req = 4'b1000; port_in = 8'hFE; wdt_ovf = 1; tick();
        wdt_ovf = 0; irq_req = 0; port_in = 8'hFF;
        chk("R8 wdt over irq and port", wake_act, 2);
        tick();
        // R8 interrupt beats port edge
        pulse_halt();
        irq_req = 4'b1000; port_in = 8'hFE; tick();
        irq_req = 0; port_in = 8'hFF;
        chk("R8 irq over port", wake_act, 1);
        tick();
        // R8 and R7 external reset beats watchdog
        pulse_halt();
        ext_rst = 1; wdt_ovf = 1; tick(); ext_rst = 0; wdt_ovf = 0;
        chk("R8 ext over wdt", wake_act, 3);
        chk("R7 pdf cleared", pdf, 0);
        chk("R7 tof cleared", tof, 0);
        chk("R7 halted cleared", halted, 0);
        tick();

        // R7 external reset while running; R9 clear and halt together
        ext_rst = 1; tick(); ext_rst = 0;
        chk("R7 running full code", wake_act, 3);
        chk("R7 running pulse", wake_valid, 1);
        halt_req = 1; wdt_clr = 1; tick(); halt_req = 0; wdt_clr = 0;
        chk("R9 halt wins over clear", pdf, 1);
        tick(2);
        summary();
    end
endmodule